// File: doc/BRIEF.md
# Storage controller capability and error monitor

This block watches a solid-state drive controller from the host side. While the
host brings the link up, a single check strobe presents three things: the
device class code, the low 64 bits of the drive's capability register and the
logical-block unit size the drive reports. The monitor compares them against the
fixed profile that the host supports. Later, while commands run, it compares
every admin and I/O completion entry with the phase tag and command identifier
the host expects. It times each outstanding admin and I/O command against a
programmable limit, and it gathers the packet-level fault flags raised by the
transport logic.

Every fault sets one bit of a 32-bit error-type vector. A bit stays set until
the synchronous active-low reset, and a single error flag is the OR of the
vector. The monitor also holds the capability fields that caused a capability
failure, and the most recent admin and I/O completion status words, so that
software-free debug logic can read them. All inputs are plain strobes that are
accepted in the cycle they are high. There is no back-pressure.

Top module: `storage_err_monitor`

## Requirements
- R1: On a cycle with `chk_valid`=1, error bit 0 is set unless `class_code` equals 24'h010802 (base [23:16]=01h, sub-class [15:8]=08h, programming interface [7:0]=02h).
- R2: On a cycle with `chk_valid`=1, error bit 1 is set if any of these holds: `cap_reg[51:48]` (minimum page size) is nonzero, `cap_reg[37]` (NVM command set) is 0, `cap_reg[35:32]` (doorbell stride) is nonzero, or `cap_reg[15:0]` (maximum queue entries) is below 7.
- R3: `cap_snap` holds {7'b0, min page size[24:21], NVM flag[20], doorbell stride[19:16], max queue entries[15:0]}. It is captured on every check strobe until error bit 1 is set, and it stays frozen after that.
- R4: On a cycle with `chk_valid`=1, error bit 16 is set unless `lba_ds` (log2 of the block size in bytes) is 9 (512 bytes) or 12 (4 KB).
- R5: On `adm_cpl_valid`, `adm_status` becomes {status[14:0], invalid}. Invalid is 1 when the phase or the command ID differs from its expected value. Error bit 3 is set when the status is nonzero or invalid is 1.
- R6: On `io_cpl_valid`, `io_status` becomes {status[14:0], invalid}. Invalid is 1 when the phase differs from its expected value. Error bit 5 is set when the status is nonzero or invalid is 1.
- R7: Call the clock edge that samples a start strobe E0. With `timeout_val`=T≠0 and no matching completion sampled at edges E0+1..E0+T, error bit 2 (admin) or bit 4 (I/O) is set by edge E0+T and not before. T=0 never sets it.
- R8: A new start strobe restarts the count from zero. A sampled completion stops it. At most one timeout is reported per start.
- R9: A strobe on `pkt_size_err`, `pkt_ecc_err`, `pkt_ur` or `pkt_ca` sets error bit 6, 7, 8 or 9 respectively.
- R10: Error bits are sticky and are cleared only by `rst_n`=0, and all outputs are zero after reset. Bits 15:10 and 31:17 always read zero. `err_flag` equals the OR of `err_type` in the same cycle. Each result is visible after the clock edge that samples its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_valid | input | 1 | Initialization check strobe |
| class_code | input | 24 | Device class code |
| cap_reg | input | 64 | Low 64 bits of controller capability register |
| lba_ds | input | 8 | log2 of reported block size in bytes |
| adm_start | input | 1 | Admin command issued, starts admin timer |
| adm_cpl_valid | input | 1 | Admin completion entry strobe |
| adm_cpl_status | input | 15 | Admin completion status field |
| adm_cpl_phase | input | 1 | Admin completion phase tag |
| adm_exp_phase | input | 1 | Expected admin phase tag |
| adm_cpl_cid | input | 16 | Admin completion command ID |
| adm_exp_cid | input | 16 | Expected admin command ID |
| io_start | input | 1 | I/O command issued, starts I/O timer |
| io_cpl_valid | input | 1 | I/O completion entry strobe |
| io_cpl_status | input | 15 | I/O completion status field |
| io_cpl_phase | input | 1 | I/O completion phase tag |
| io_exp_phase | input | 1 | Expected I/O phase tag |
| pkt_size_err | input | 1 | Completion packet size mismatch strobe |
| pkt_ecc_err | input | 1 | Receive buffer ECC error strobe |
| pkt_ur | input | 1 | Unsupported request flag strobe |
| pkt_ca | input | 1 | Completer abort flag strobe |
| timeout_val | input | 32 | Completion timeout in clock cycles, 0 disables |
| err_type | output | 32 | Sticky error-type vector |
| err_flag | output | 1 | OR of err_type |
| cap_snap | output | 32 | Captured capability fields |
| adm_status | output | 16 | Last admin completion status word |
| io_status | output | 16 | Last I/O completion status word |

## Verification
Every check-strobe, completion and packet-flag result is registered once, so the bench drives a strobe before one rising edge and reads the outputs at the following falling edge. There it expects `err_flag` to agree with `err_type` at once. A timeout is due exactly T edges after the edge that sampled the start strobe. In each timeout case the bench therefore samples after every edge from E0+1 to E0+10 and expects the bit to be clear before edge E0+T and set from it onward, unless a completion arrived inside the window. Each case starts from a reset, so the sticky vector from one case cannot hide the result of the next.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned ERR_W = 32;
  localparam int B_CLASS = 0;
  localparam int B_CAP   = 1;
  localparam int B_ATMO  = 2;
  localparam int B_ACPL  = 3;
  localparam int B_ITMO  = 4;
  localparam int B_ICPL  = 5;
  localparam int B_PKT0  = 6;   // R9: size, ecc, ur, ca occupy B_PKT0..B_PKT0+3
  localparam int N_PKT   = 4;
  localparam int B_LBA   = 16;
  localparam logic [23:0] CLASS_OK = 24'h010802;

  typedef struct packed {
    logic [6:0]  rsvd;
    logic [3:0]  mps;
    logic        nvm;
    logic [3:0]  dstrd;
    logic [15:0] mqes;
  } cap_snap_t;
endpackage

// File: rtl/sem_cap_check.sv
module sem_cap_check
  import sem_pkg::*;
#(
  parameter int MQES_MIN  = 7,
  parameter int LBA_SMALL = 9,
  parameter int LBA_LARGE = 12
) (
  input  logic        chk_valid,
  input  logic [23:0] class_code,
  input  logic [63:0] cap_reg,
  input  logic [7:0]  lba_ds,
  output logic        class_err,
  output logic        cap_err,
  output logic        lba_err,
  output cap_snap_t   fields
);
  logic cap_unused;
  assign cap_unused = ^{cap_reg[63:52], cap_reg[47:38], cap_reg[36], cap_reg[31:16]};

  always_comb begin
    fields       = '0;
    fields.mqes  = cap_reg[15:0];
    fields.dstrd = cap_reg[35:32];
    fields.nvm   = cap_reg[37];
    fields.mps   = cap_reg[51:48];
  end

  // R1: class code profile
  assign class_err = chk_valid && (class_code != CLASS_OK);
  // R2: capability rules
  assign cap_err = chk_valid && ((fields.mps != 4'd0) || !fields.nvm ||
                   (fields.dstrd != 4'd0) || (fields.mqes < 16'(MQES_MIN)));
  // R4: block size must be one of the two supported units
  assign lba_err = chk_valid && (lba_ds != 8'(LBA_SMALL)) && (lba_ds != 8'(LBA_LARGE));
endmodule

// File: rtl/sem_cpl_track.sv
module sem_cpl_track #(
  parameter int TMO_W  = 32,
  parameter int STAT_W = 15,
  parameter int CID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpl_valid,
  input  logic [STAT_W-1:0] cpl_status,
  input  logic              cpl_phase,
  input  logic              exp_phase,
  input  logic [CID_W-1:0]  cpl_cid,
  input  logic [CID_W-1:0]  exp_cid,
  input  logic [TMO_W-1:0]  timeout_val,
  output logic              tmo_fire,
  output logic              bad_cpl,
  output logic [STAT_W:0]   status_word
);
  localparam int CW = TMO_W + 1;

  logic             busy_q;
  logic [TMO_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_next;
  logic             invalid;

  assign cnt_next = {1'b0, cnt_q} + CW'(1);
  assign invalid  = (cpl_phase != exp_phase) || (cpl_cid != exp_cid);
  assign bad_cpl  = cpl_valid && ((cpl_status != '0) || invalid);   // R5, R6

  // R7: window expires on the T-th edge after the arming edge
  assign tmo_fire = busy_q && !start && !cpl_valid && (timeout_val != '0) &&
                    (cnt_next >= {1'b0, timeout_val});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin          // R8: restart
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cpl_valid || tmo_fire) busy_q <= 1'b0;
      else                       cnt_q  <= cnt_q + TMO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         status_word <= '0;
    else if (cpl_valid) status_word <= {cpl_status, invalid};
  end

  p_start_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0));
  p_cpl_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cpl_valid && !start) |=> !busy_q);
  p_single_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> !tmo_fire);
endmodule

// File: rtl/storage_err_monitor.sv
module storage_err_monitor
  import sem_pkg::*;
#(
  parameter int TMO_W  = 32,
  parameter int STAT_W = 15,
  parameter int CID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [23:0]       class_code,
  input  logic [63:0]       cap_reg,
  input  logic [7:0]        lba_ds,
  input  logic              adm_start,
  input  logic              adm_cpl_valid,
  input  logic [STAT_W-1:0] adm_cpl_status,
  input  logic              adm_cpl_phase,
  input  logic              adm_exp_phase,
  input  logic [CID_W-1:0]  adm_cpl_cid,
  input  logic [CID_W-1:0]  adm_exp_cid,
  input  logic              io_start,
  input  logic              io_cpl_valid,
  input  logic [STAT_W-1:0] io_cpl_status,
  input  logic              io_cpl_phase,
  input  logic              io_exp_phase,
  input  logic              pkt_size_err,
  input  logic              pkt_ecc_err,
  input  logic              pkt_ur,
  input  logic              pkt_ca,
  input  logic [TMO_W-1:0]  timeout_val,
  output logic [ERR_W-1:0]  err_type,
  output logic              err_flag,
  output logic [31:0]       cap_snap,
  output logic [STAT_W:0]   adm_status,
  output logic [STAT_W:0]   io_status
);
  logic      class_err, cap_err, lba_err;
  cap_snap_t fields;
  logic      adm_fire, adm_bad, io_fire, io_bad;
  logic [N_PKT-1:0] pkt_vec;
  logic [ERR_W-1:0] set_vec;
  logic [ERR_W-1:0] err_q;
  cap_snap_t        snap_q;

  sem_cap_check u_cap (
    .chk_valid (chk_valid), .class_code (class_code), .cap_reg (cap_reg),
    .lba_ds (lba_ds), .class_err (class_err), .cap_err (cap_err),
    .lba_err (lba_err), .fields (fields)
  );

  sem_cpl_track #(.TMO_W(TMO_W), .STAT_W(STAT_W), .CID_W(CID_W)) u_adm (
    .clk (clk), .rst_n (rst_n), .start (adm_start), .cpl_valid (adm_cpl_valid),
    .cpl_status (adm_cpl_status), .cpl_phase (adm_cpl_phase),
    .exp_phase (adm_exp_phase), .cpl_cid (adm_cpl_cid), .exp_cid (adm_exp_cid),
    .timeout_val (timeout_val), .tmo_fire (adm_fire), .bad_cpl (adm_bad),
    .status_word (adm_status)
  );

  // I/O entries carry no identifier check: both ID pins tied equal
  sem_cpl_track #(.TMO_W(TMO_W), .STAT_W(STAT_W), .CID_W(CID_W)) u_io (
    .clk (clk), .rst_n (rst_n), .start (io_start), .cpl_valid (io_cpl_valid),
    .cpl_status (io_cpl_status), .cpl_phase (io_cpl_phase),
    .exp_phase (io_exp_phase), .cpl_cid ('0), .exp_cid ('0),
    .timeout_val (timeout_val), .tmo_fire (io_fire), .bad_cpl (io_bad),
    .status_word (io_status)
  );

  assign pkt_vec = {pkt_ca, pkt_ur, pkt_ecc_err, pkt_size_err};

  always_comb begin
    set_vec         = '0;
    set_vec[B_CLASS] = class_err;
    set_vec[B_CAP]   = cap_err;
    set_vec[B_ATMO]  = adm_fire;
    set_vec[B_ACPL]  = adm_bad;
    set_vec[B_ITMO]  = io_fire;
    set_vec[B_ICPL]  = io_bad;
    set_vec[B_LBA]   = lba_err;
    for (int i = 0; i < N_PKT; i++) set_vec[B_PKT0 + i] = pkt_vec[i];  // R9
  end

  // R10: sticky accumulation
  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_q | set_vec;
  end

  // R3: capture until a capability failure has been latched
  always_ff @(posedge clk) begin
    if (!rst_n)                         snap_q <= '0;
    else if (chk_valid && !err_q[B_CAP]) snap_q <= fields;
  end

  assign err_type = err_q;
  assign err_flag = |err_q;
  assign cap_snap = snap_q;

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));
  p_adm_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adm_fire |=> err_q[B_ATMO]);
  p_io_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_fire |=> err_q[B_ITMO]);
  p_cap_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q[B_CAP] |=> $stable(snap_q));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> (err_q[15:10] == 6'd0 && err_q[31:17] == 15'd0));
endmodule

// File: tb/storage_err_monitor_test.sv
module storage_err_monitor_test;
  logic clk = 1'b0;
  logic rst_n;
  logic chk_valid;
  logic [23:0] class_code;
  logic [63:0] cap_reg;
  logic [7:0]  lba_ds;
  logic adm_start, adm_cpl_valid, adm_cpl_phase, adm_exp_phase;
  logic [14:0] adm_cpl_status, io_cpl_status;
  logic [15:0] adm_cpl_cid, adm_exp_cid;
  logic io_start, io_cpl_valid, io_cpl_phase, io_exp_phase;
  logic pkt_size_err, pkt_ecc_err, pkt_ur, pkt_ca;
  logic [31:0] timeout_val;
  logic [31:0] err_type, cap_snap;
  logic        err_flag;
  logic [15:0] adm_status, io_status;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  storage_err_monitor uut (
    .clk (clk), .rst_n (rst_n), .chk_valid (chk_valid), .class_code (class_code),
    .cap_reg (cap_reg), .lba_ds (lba_ds), .adm_start (adm_start),
    .adm_cpl_valid (adm_cpl_valid), .adm_cpl_status (adm_cpl_status),
    .adm_cpl_phase (adm_cpl_phase), .adm_exp_phase (adm_exp_phase),
    .adm_cpl_cid (adm_cpl_cid), .adm_exp_cid (adm_exp_cid), .io_start (io_start),
    .io_cpl_valid (io_cpl_valid), .io_cpl_status (io_cpl_status),
    .io_cpl_phase (io_cpl_phase), .io_exp_phase (io_exp_phase),
    .pkt_size_err (pkt_size_err), .pkt_ecc_err (pkt_ecc_err), .pkt_ur (pkt_ur),
    .pkt_ca (pkt_ca), .timeout_val (timeout_val), .err_type (err_type),
    .err_flag (err_flag), .cap_snap (cap_snap), .adm_status (adm_status),
    .io_status (io_status)
  );

  localparam logic [63:0] CAP_GOOD = 64'h0000_0020_0000_00FF;

  function automatic logic [63:0] mk_cap(int mqes, int dstrd, int mps, bit nvm);
    logic [63:0] c = '0;
    c[15:0]  = 16'(mqes);
    c[35:32] = 4'(dstrd);
    c[37]    = nvm;
    c[51:48] = 4'(mps);
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    chk_valid = 0; class_code = 24'h010802; cap_reg = CAP_GOOD; lba_ds = 8'd9;
    adm_start = 0; adm_cpl_valid = 0; adm_cpl_status = '0; adm_cpl_phase = 0;
    adm_exp_phase = 0; adm_cpl_cid = '0; adm_exp_cid = '0;
    io_start = 0; io_cpl_valid = 0; io_cpl_status = '0; io_cpl_phase = 0;
    io_exp_phase = 0; pkt_size_err = 0; pkt_ecc_err = 0; pkt_ur = 0; pkt_ca = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // drive one strobe cycle set up by caller, then return idle after the edge
  task automatic pulse();
    @(negedge clk);
    chk_valid = 0; adm_start = 0; adm_cpl_valid = 0; io_start = 0; io_cpl_valid = 0;
    pkt_size_err = 0; pkt_ecc_err = 0; pkt_ur = 0; pkt_ca = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; timeout_val = 0; idle();
    do_reset();
    // R10 reset state
    chk("R10 reset err_type", err_type, 0);
    chk("R10 reset err_flag", {31'd0, err_flag}, 0);
    chk("R10 reset cap_snap", cap_snap, 0);
    chk("R10 reset adm_status", {16'd0, adm_status}, 0);
    chk("R10 reset io_status", {16'd0, io_status}, 0);

    // R1 class code sweep
    for (int b = 0; b < 4; b++)
      for (int s = 6; s < 10; s++)
        for (int p = 0; p < 4; p++) begin
          do_reset(); idle();
          class_code = {8'(b), 8'(s), 8'(p)}; chk_valid = 1;
          pulse();
          chk("R1 class code", err_type,
              (b == 1 && s == 8 && p == 2) ? 32'h0 : 32'h1);
          chk("R10 flag follows vector", {31'd0, err_flag},
              (b == 1 && s == 8 && p == 2) ? 32'h0 : 32'h1);
        end

    // R2 / R3 capability sweep
    for (int q = 0; q < 11; q++)
      for (int di = 0; di < 3; di++)
        for (int mi = 0; mi < 3; mi++)
          for (int n = 0; n < 2; n++) begin
            automatic int d = (di == 2) ? 15 : di;
            automatic int m = (mi == 2) ? 15 : mi;
            automatic bit bad = (m != 0) || (n == 0) || (d != 0) || (q < 7);
            do_reset(); idle();
            cap_reg = mk_cap(q, d, m, n[0]); chk_valid = 1;
            pulse();
            chk("R2 capability", err_type, bad ? 32'h2 : 32'h0);
            chk("R3 snapshot", cap_snap,
                {7'd0, 4'(m), n[0], 4'(d), 16'(q)});
          end

    // R3 freeze after failure, update while passing
    do_reset(); idle();
    cap_reg = mk_cap(100, 0, 0, 1); chk_valid = 1; pulse();
    cap_reg = mk_cap(3, 0, 0, 1); chk_valid = 1; pulse();
    chk("R3 snapshot on failure", cap_snap, 32'h0010_0003);
    cap_reg = mk_cap(9, 2, 0, 1); chk_valid = 1; pulse();
    chk("R3 snapshot frozen", cap_snap, 32'h0010_0003);

    // R4 block size sweep
    for (int l = 0; l < 16; l++) begin
      do_reset(); idle();
      lba_ds = 8'(l); chk_valid = 1; pulse();
      chk("R4 lba unit", err_type, (l == 9 || l == 12) ? 32'h0 : 32'h0001_0000);
    end

    // R5 / R6 completion entries
    for (int si = 0; si < 3; si++)
      for (int pm = 0; pm < 2; pm++)
        for (int cm = 0; cm < 2; cm++) begin
          automatic logic [14:0] st = (si == 0) ? 15'd0 : (si == 1) ? 15'd1 : 15'h7FFF;
          automatic bit abad = (st != 0) || pm != 0 || cm != 0;
          do_reset(); idle();
          adm_exp_phase = 1; adm_cpl_phase = (pm != 0) ? 1'b0 : 1'b1;
          adm_exp_cid = 16'h1234; adm_cpl_cid = (cm != 0) ? 16'h1235 : 16'h1234;
          adm_cpl_status = st; adm_cpl_valid = 1; pulse();
          chk("R5 admin status word", {16'd0, adm_status},
              {16'd0, st, (pm != 0 || cm != 0)});
          chk("R5 admin error bit", err_type, abad ? 32'h8 : 32'h0);
          do_reset(); idle();
          io_exp_phase = 0; io_cpl_phase = (pm != 0);
          io_cpl_status = st; io_cpl_valid = 1; pulse();
          chk("R6 io status word", {16'd0, io_status}, {16'd0, st, (pm != 0)});
          chk("R6 io error bit", err_type,
              ((st != 0) || pm != 0) ? 32'h20 : 32'h0);
        end

    // R9 packet flags
    for (int i = 0; i < 4; i++) begin
      do_reset(); idle();
      pkt_size_err = (i == 0); pkt_ecc_err = (i == 1); pkt_ur = (i == 2); pkt_ca = (i == 3);
      pulse();
      chk("R9 packet flag", err_type, 32'h1 << (6 + i));
      chk("R9 packet flag raises err_flag", {31'd0, err_flag}, 32'h1);
    end

    // R7 timeout sweep, sampled after every edge
    for (int qsel = 0; qsel < 2; qsel++)
      for (int t = 0; t < 7; t++)
        for (int k = 0; k < 9; k++) begin
          do_reset(); idle();
          timeout_val = 32'(t);
          @(negedge clk);
          if (qsel == 0) adm_start = 1; else io_start = 1;
          pulse();                       // edge E0 has sampled the start
          for (int j = 1; j <= 10; j++) begin
            automatic bit fired;
            if (qsel == 0) adm_cpl_valid = (j == k); else io_cpl_valid = (j == k);
            @(negedge clk);
            adm_cpl_valid = 0; io_cpl_valid = 0;
            fired = (t != 0) && (j >= t) && !(k >= 1 && k <= t);
            chk(qsel == 0 ? "R7 admin timeout" : "R7 io timeout", err_type,
                fired ? ((qsel == 0) ? 32'h4 : 32'h10) : 32'h0);
          end
        end

    // R8 restart
    do_reset(); idle(); timeout_val = 4;
    @(negedge clk); adm_start = 1; pulse();
    repeat (2) @(negedge clk);
    adm_start = 1; pulse();              // re-armed at E0+3
    repeat (3) @(negedge clk);
    chk("R8 restart delays timeout", err_type, 32'h0);
    @(negedge clk);
    chk("R8 restarted timeout fires", err_type, 32'h4);
    // R8 one report per start, start ignored by stopped timer
    do_reset(); idle(); timeout_val = 2;
    @(negedge clk); io_start = 1; pulse();
    repeat (6) @(negedge clk);
    chk("R8 single io timeout", err_type, 32'h10);

    // R10 all sources in one cycle, sticky, then reset
    do_reset(); idle(); timeout_val = 0;
    class_code = 24'h010801; cap_reg = mk_cap(1, 0, 0, 1); lba_ds = 8'd10; chk_valid = 1;
    adm_cpl_valid = 1; adm_cpl_status = 15'd2; io_cpl_valid = 1; io_cpl_status = 15'd3;
    pkt_size_err = 1; pkt_ecc_err = 1; pkt_ur = 1; pkt_ca = 1;
    pulse();
    timeout_val = 1; adm_start = 1; io_start = 1; pulse();
    @(negedge clk);
    chk("R10 all sources, reserved zero", err_type, 32'h0001_03FF);
    repeat (5) @(negedge clk);
    chk("R10 sticky", err_type, 32'h0001_03FF);
    chk("R10 flag high", {31'd0, err_flag}, 32'h1);
    do_reset();
    chk("R10 reset clears vector", err_type, 32'h0);
    chk("R10 reset clears flag", {31'd0, err_flag}, 32'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule